// File: doc/BRIEF.md
# Three-Channel Reloading Down-Timer

This block is a timer peripheral with three independent channels behind a simple single-cycle register bus. Each channel owns a 32-bit down-counter and a 32-bit reload constant. It also has its own tick source, which is either a shared prescaled division of the peripheral clock or an external count-enable input. A shared run register holds one enable bit per channel. While a channel's bit is set, the channel counts down one step on every selected tick.

When a tick arrives while a running counter already holds zero, the counter takes the reload constant instead of wrapping, and it keeps counting. The count period is therefore the constant plus one tick. The same event sets a sticky underflow flag in that channel's control register. Software clears the flag explicitly. While the flag is set and the channel's interrupt enable is on, the channel's interrupt line is held high, so a handler that fails to clear the flag sees the request again at once.

Software sets up a channel in this order: choose the tick source and interrupt enable, write the reload constant, optionally write a starting count, and then set the run bit.

Top module: `rtimer_top`

## Requirements
- R1: After reset every counter, reload constant, run bit, tick-source code, interrupt enable and underflow flag reads as zero, and all interrupt lines are low.
- R2: Word address 0 is the run register, with bit c enabling channel c. A channel whose run bit is 0 holds its count unchanged whatever its tick source does.
- R3: A shared prescale counter is cleared by reset and advances every clock. A channel with source code k in 0..4 ticks on each edge where that counter, taken modulo 4^(k+1) (4, 16, 64, 256, 1024), equals 4^(k+1)-1. Code 5 ticks on each edge where the external count-enable input is high. Codes 6 and 7 behave as code 0.
- R4: On a tick, a running counter that holds a nonzero value decrements by one. A running counter that holds zero loads the reload constant in force before that edge. The period is thus constant+1 ticks, and a constant of 0 reloads on every tick.
- R5: An underflow (a tick while the counter holds zero) sets the channel's flag, control bit 8. The flag stays set until a clear.
- R6: A control write with bit 8 = 0 clears the flag, and a control write with bit 8 = 1 leaves the flag unchanged. An underflow on the same edge as a clearing write leaves the flag set.
- R7: Each channel's interrupt line is high exactly while its flag is set and its enable, control bit 5, is 1. The line is a level, not a pulse.
- R8: A write to a channel's count register loads the written value on that edge. The write takes priority over a tick on the same edge, and that edge produces no underflow. The count write is independent of the reload constant.
- R9: Channel c (0..2) occupies word addresses 4(c+1) for control (bits 2:0 source code, bit 5 enable, bit 8 flag, other bits zero), 4(c+1)+1 for the constant and 4(c+1)+2 for the count. All of these read back combinationally, and unmapped addresses read zero.
- R10: The channels are independent: a write or tick on one channel never alters another channel's count, constant, flag or interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extCount | input | 1 | External count-enable, one tick per high clock edge for source code 5 |
| busSel | input | 1 | Register access select |
| busWrite | input | 1 | Write when high, read when low |
| busAddr | input | 4 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| irq | output | 3 | Per-channel interrupt request levels |

## Verification
The counting path is tried with every prescale code, including a reserved one and the slowest division. Read back each cycle, these runs tell a correct divisor and phase apart from an off-by-one in either, and they tell a reload at the zero tick apart from a wrap or an early reload. The external tick source makes exact edge collisions possible: a clearing write on the same edge as an underflow, a count write on the same edge as a tick at zero, and a constant of zero. These collisions separate the priority orderings from one another. Runs with the interrupt enable off, with a write that keeps the flag and with a run bit cleared show that the sticky flag, the interrupt level and the hold behaviour act apart from one another.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;
  parameter int NUM_CH       = 3;
  parameter int CNT_W        = 32;
  parameter int SEL_W        = 3;
  parameter int DIV_STEPS    = 5;
  parameter int DIV_BASE_LOG = 2;
  parameter int DIV_STEP_LOG = 2;

  localparam int PSC_W     = DIV_BASE_LOG + (DIV_STEPS - 1) * DIV_STEP_LOG;
  localparam int CH_IDX_W  = $clog2(NUM_CH + 1);
  localparam int REG_IDX_W = 2;
  localparam int ADDR_W    = CH_IDX_W + REG_IDX_W;
  localparam int IE_BIT    = 5;
  localparam int FLAG_BIT  = 8;
  localparam logic [SEL_W-1:0] EXT_CODE = SEL_W'(5);

  typedef enum logic [REG_IDX_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_CONST = 2'd1,
    REG_COUNT = 2'd2,
    REG_SPARE = 2'd3
  } regIdx_e;

  // Per-channel strobes from control to datapath
  typedef struct packed {
    logic tick;
    logic wrConst;
    logic wrCount;
    logic flagClr;
  } chStrobe_t;
endpackage

// File: rtl/rtimer_prescaler.sv
module rtimer_prescaler
  import rtimer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  output logic [DIV_STEPS-1:0] divTick
);
  logic [PSC_W-1:0] psc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) psc <= '0;
    else       psc <= psc + PSC_W'(1);
  end

  for (genvar k = 0; k < DIV_STEPS; k++) begin : g_div
    localparam int LW = DIV_BASE_LOG + k * DIV_STEP_LOG;
    assign divTick[k] = &psc[LW-1:0];
  end

  // R3: the fastest division never ticks on two adjacent edges
  p_div_spacing_r3: assert property (@(posedge clk) disable iff (!rstN)
    divTick[0] |=> !divTick[0]);

  // R3: the slowest division marks the wrap of the shared counter
  p_div_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    divTick[DIV_STEPS-1] |=> (psc == '0));
endmodule

// File: rtl/rtimer_ctrl.sv
module rtimer_ctrl
  import rtimer_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            extCount,
  input  logic                            busSel,
  input  logic                            busWrite,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic [SEL_W-1:0]                wrSel,
  input  logic                            wrIe,
  input  logic                            wrFlagKeep,
  input  logic [NUM_CH-1:0]               wrRun,
  input  logic [DIV_STEPS-1:0]            divTick,
  input  logic [NUM_CH-1:0][CNT_W-1:0]    cntVal,
  input  logic [NUM_CH-1:0][CNT_W-1:0]    constVal,
  input  logic [NUM_CH-1:0]               flagVal,
  output chStrobe_t [NUM_CH-1:0]          strobes,
  output logic [CNT_W-1:0]                busRdata,
  output logic [NUM_CH-1:0]               irq
);
  logic                  wrEn;
  logic [CH_IDX_W-1:0]   chField;
  regIdx_e               regField;
  logic                  startHit;
  logic [NUM_CH-1:0]     runBits;
  logic [NUM_CH-1:0][SEL_W-1:0] selReg;
  logic [NUM_CH-1:0]     ieReg;
  logic [NUM_CH-1:0]     chHit;
  logic [NUM_CH-1:0]     clkTick;

  assign wrEn     = busSel & busWrite;
  assign chField  = busAddr[ADDR_W-1:REG_IDX_W];
  assign regField = regIdx_e'(busAddr[REG_IDX_W-1:0]);
  assign startHit = (chField == '0) && (regField == REG_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                runBits <= '0;
    else if (wrEn && startHit) runBits <= wrRun;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign chHit[c] = (chField == CH_IDX_W'(c + 1));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selReg[c] <= '0;
        ieReg[c]  <= 1'b0;
      end else if (wrEn && chHit[c] && regField == REG_CTRL) begin
        selReg[c] <= wrSel;
        ieReg[c]  <= wrIe;
      end
    end

    always_comb begin
      if (selReg[c] == EXT_CODE)
        clkTick[c] = extCount;
      else if (int'(selReg[c]) < DIV_STEPS)
        clkTick[c] = divTick[selReg[c]];
      else
        clkTick[c] = divTick[0];
    end

    assign strobes[c].tick    = runBits[c] & clkTick[c];
    assign strobes[c].wrConst = wrEn & chHit[c] & (regField == REG_CONST);
    assign strobes[c].wrCount = wrEn & chHit[c] & (regField == REG_COUNT);
    assign strobes[c].flagClr = wrEn & chHit[c] & (regField == REG_CTRL) & ~wrFlagKeep;
    assign irq[c]             = flagVal[c] & ieReg[c];

    // R9: a control write lands in the source and enable fields
    p_ctrl_load_r9: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && chHit[c] && regField == REG_CTRL) |=>
        (selReg[c] == $past(wrSel)) && (ieReg[c] == $past(wrIe)));
  end

  always_comb begin
    busRdata = '0;
    if (startHit) busRdata = CNT_W'(runBits);
    for (int c = 0; c < NUM_CH; c++) begin
      if (chHit[c]) begin
        case (regField)
          REG_CTRL: begin
            busRdata[SEL_W-1:0] = selReg[c];
            busRdata[IE_BIT]    = ieReg[c];
            busRdata[FLAG_BIT]  = flagVal[c];
          end
          REG_CONST: busRdata = constVal[c];
          REG_COUNT: busRdata = cntVal[c];
          default:   busRdata = '0;
        endcase
      end
    end
  end

  // R2: a start-register write replaces all run bits
  p_start_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && startHit) |=> (runBits == $past(wrRun)));
endmodule

// File: rtl/rtimer_datapath.sv
module rtimer_datapath
  import rtimer_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  chStrobe_t [NUM_CH-1:0]       strobes,
  input  logic [CNT_W-1:0]             wrData,
  output logic [NUM_CH-1:0][CNT_W-1:0] cntVal,
  output logic [NUM_CH-1:0][CNT_W-1:0] constVal,
  output logic [NUM_CH-1:0]            flagVal
);
  logic [NUM_CH-1:0] underflow;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign underflow[c] = strobes[c].tick & ~strobes[c].wrCount & (cntVal[c] == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  cntVal[c] <= '0;
      else if (strobes[c].wrCount) cntVal[c] <= wrData;
      else if (strobes[c].tick)    cntVal[c] <= (cntVal[c] == '0) ? constVal[c]
                                                                 : cntVal[c] - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  constVal[c] <= '0;
      else if (strobes[c].wrConst) constVal[c] <= wrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  flagVal[c] <= 1'b0;
      else if (underflow[c])       flagVal[c] <= 1'b1;
      else if (strobes[c].flagClr) flagVal[c] <= 1'b0;
    end

    // R4: tick at zero reloads from the constant held before the edge
    p_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
      (strobes[c].tick && !strobes[c].wrCount && cntVal[c] == '0) |=>
        (cntVal[c] == $past(constVal[c])));

    // R4: tick at a nonzero value steps down by one
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rstN)
      (strobes[c].tick && !strobes[c].wrCount && cntVal[c] != '0) |=>
        (cntVal[c] == $past(cntVal[c]) - CNT_W'(1)));

    // R2: with no tick and no write the count holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes[c].tick && !strobes[c].wrCount) |=> $stable(cntVal[c]));

    // R8: a count write wins over a tick
    p_count_write_r8: assert property (@(posedge clk) disable iff (!rstN)
      strobes[c].wrCount |=> (cntVal[c] == $past(wrData)));

    // R5 and R6: underflow sets the flag even against a clear
    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rstN)
      underflow[c] |=> flagVal[c]);

    // R5: the flag only falls through a clearing write
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
      (flagVal[c] && !strobes[c].flagClr) |=> flagVal[c]);
  end
endmodule

// File: rtl/rtimer_top.sv
module rtimer_top
  import rtimer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              extCount,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic [NUM_CH-1:0] irq
);
  logic [DIV_STEPS-1:0]         divTick;
  chStrobe_t [NUM_CH-1:0]       strobes;
  logic [NUM_CH-1:0][CNT_W-1:0] cntVal;
  logic [NUM_CH-1:0][CNT_W-1:0] constVal;
  logic [NUM_CH-1:0]            flagVal;

  rtimer_prescaler u_prescaler (
    .clk     (clk),
    .rstN    (rstN),
    .divTick (divTick)
  );

  rtimer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .extCount   (extCount),
    .busSel     (busSel),
    .busWrite   (busWrite),
    .busAddr    (busAddr),
    .wrSel      (busWdata[SEL_W-1:0]),
    .wrIe       (busWdata[IE_BIT]),
    .wrFlagKeep (busWdata[FLAG_BIT]),
    .wrRun      (busWdata[NUM_CH-1:0]),
    .divTick    (divTick),
    .cntVal     (cntVal),
    .constVal   (constVal),
    .flagVal    (flagVal),
    .strobes    (strobes),
    .busRdata   (busRdata),
    .irq        (irq)
  );

  rtimer_datapath u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (busWdata),
    .cntVal   (cntVal),
    .constVal (constVal),
    .flagVal  (flagVal)
  );
endmodule

// File: tb/test_rtimer_top.sv
`timescale 1ns/1ps
module test_rtimer_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extCount = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtimer_top i_rtimer_top (
    .clk(clk), .rstN(rstN), .extCount(extCount), .busSel(busSel),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irq(irq)
  );

  // Behavioural reference model
  logic [31:0] mCnt[3];
  logic [31:0] mConst[3];
  logic [2:0]  mSel[3];
  bit          mIe[3];
  bit          mFlag[3];
  bit   [2:0]  mRun;
  int          mPsc;

  function automatic bit mTick(input logic [2:0] s, input int p, input bit e);
    int n;
    if (s == 3'd5) return e;
    n = (s <= 3'd4) ? (4 << (2 * s)) : 4;
    return (p % n) == n - 1;
  endfunction

  function automatic logic [31:0] mRead(input int a);
    int ch = a >> 2;
    int rg = a & 3;
    if (a == 0) return {29'd0, mRun};
    if (ch >= 1 && ch <= 3) begin
      case (rg)
        0: return (32'(mFlag[ch-1]) << 8) | (32'(mIe[ch-1]) << 5) | 32'(mSel[ch-1]);
        1: return mConst[ch-1];
        2: return mCnt[ch-1];
        default: return 32'd0;
      endcase
    end
    return 32'd0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    bit wr, tk, unf, clr;
    int ch, rg;
    if (!rstN) begin
      for (int c = 0; c < 3; c++) begin
        mCnt[c] = 0; mConst[c] = 0; mSel[c] = 0; mIe[c] = 0; mFlag[c] = 0;
      end
      mRun = 0;
      mPsc = 0;
    end else begin
      wr = busSel && busWrite;
      ch = int'(busAddr) >> 2;
      rg = int'(busAddr) & 3;
      for (int c = 0; c < 3; c++) begin
        tk = mRun[c] && mTick(mSel[c], mPsc, extCount);
        unf = 0;
        clr = 0;
        if (wr && ch == c + 1 && rg == 2) mCnt[c] = busWdata;
        else if (tk) begin
          if (mCnt[c] == 0) begin mCnt[c] = mConst[c]; unf = 1; end
          else mCnt[c] = mCnt[c] - 1;
        end
        if (wr && ch == c + 1 && rg == 1) mConst[c] = busWdata;
        if (wr && ch == c + 1 && rg == 0) begin
          mSel[c] = busWdata[2:0];
          mIe[c]  = busWdata[5];
          clr     = !busWdata[8];
        end
        if (unf) mFlag[c] = 1;
        else if (clr) mFlag[c] = 0;
      end
      if (wr && ch == 0 && rg == 0) mRun = busWdata[2:0];
      mPsc++;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // R7: interrupt levels compared on every cycle
  always @(negedge clk) begin
    if (rstN && !done)
      check("R7 irq", {29'd0, irq},
            {29'd0, mFlag[2] & mIe[2], mFlag[1] & mIe[1], mFlag[0] & mIe[0]});
  end

  task automatic wrx(input int a, input logic [31:0] d, input bit e);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = 4'(a); busWdata = d; extCount = e;
    @(negedge clk);
    busSel = 0; busWrite = 0; extCount = 0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wrx(a, d, 1'b0);
  endtask

  task automatic watch(input int a, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      busAddr = 4'(a);
      #1 check(tag, busRdata, mRead(a));
    end
  endtask

  task automatic extPulse(input int a, input string tag);
    @(negedge clk);
    extCount = 1;
    busAddr = 4'(a);
    @(negedge clk);
    extCount = 0;
    #1 check(tag, busRdata, mRead(a));
  endtask

  task automatic summary;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog (all requirements): run did not complete");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    // R1: reset values across the whole map
    foreach (mCnt[i]) begin end
    watch(0, 1, "R1 run");
    for (int c = 0; c < 3; c++) begin
      watch(4 * (c + 1), 1, "R1 ctrl");
      watch(4 * (c + 1) + 1, 1, "R1 const");
      watch(4 * (c + 1) + 2, 1, "R1 count");
    end
    check("R1 irq", {29'd0, irq}, 32'd0);

    // R9: register map read-back, unmapped address reads zero
    wr(5, 32'd5);
    wr(4, 32'h0000_0020);
    wr(6, 32'd3);
    wr(9, 32'hFFFF_FFFF);
    watch(4, 1, "R9 ctrl");
    watch(5, 1, "R9 const");
    watch(6, 1, "R9 count");
    watch(9, 1, "R9 const all ones");
    watch(3, 1, "R9 unmapped");
    watch(15, 1, "R9 unmapped");
    wr(9, 32'd2);

    // R2: stopped counter holds
    watch(6, 12, "R2 hold before start");
    // R4: run channel 0 at divide-by-4 through several reloads
    wr(0, 32'd1);
    watch(6, 60, "R4 count/reload ch0");
    // R5: flag visible and sticky
    watch(4, 3, "R5 flag ch0");
    // R6: write keeping flag, then clearing write
    wr(4, 32'h0000_0120);
    watch(4, 1, "R6 keep flag");
    wr(4, 32'h0000_0020);
    watch(4, 1, "R6 clear flag");
    // R7: enable off, flag rises, irq stays low; enable back with flag kept
    wr(4, 32'h0000_0000);
    watch(4, 40, "R7 flag without enable");
    wr(4, 32'h0000_0120);
    watch(4, 5, "R7 enable with flag kept");

    // R3: channel 1 divide-by-16
    wr(8, 32'h0000_0021);
    wr(10, 32'd2);
    wr(0, 32'd3);
    watch(10, 120, "R3 div16 ch1");
    // R3: reserved code acts as divide-by-4
    wr(8, 32'h0000_0006);
    watch(10, 40, "R3 reserved code ch1");
    // R3: divide-by-64 and divide-by-256
    wr(8, 32'h0000_0002);
    watch(10, 300, "R3 div64 ch1");
    wr(8, 32'h0000_0003);
    watch(10, 1100, "R3 div256 ch1");
    // R3: divide-by-1024 with constant 1
    wr(8, 32'h0000_0024);
    wr(9, 32'd1);
    wr(10, 32'd1);
    watch(10, 4200, "R3 div1024 ch1");
    // R10: channel 0 kept its own course
    watch(6, 4, "R10 ch0 independent");
    watch(5, 1, "R10 ch0 const");

    // R3: external count-enable on channel 2
    wr(12, 32'h0000_0025);
    wr(13, 32'd7);
    wr(14, 32'd0);
    wr(0, 32'd7);
    watch(14, 10, "R3 ext idle holds");
    extPulse(14, "R4 ext underflow reload");
    watch(12, 1, "R5 ext flag set");
    extPulse(14, "R4 ext decrement");
    // R6: clearing write on the same edge as an underflow keeps flag
    wr(14, 32'd0);
    wrx(12, 32'h0000_0025, 1'b1);
    watch(12, 1, "R6 underflow beats clear");
    watch(14, 1, "R6 reload on clear edge");
    wr(12, 32'h0000_0025);
    watch(12, 1, "R6 clear after collision");
    // R8: count write on the same edge as a tick at zero
    wr(14, 32'd0);
    wrx(14, 32'd9, 1'b1);
    watch(14, 1, "R8 write beats tick");
    watch(12, 1, "R8 no underflow on write edge");
    // R4: constant zero reloads every tick
    wr(13, 32'd0);
    wr(14, 32'd0);
    extPulse(14, "R4 const zero");
    extPulse(14, "R4 const zero");
    watch(12, 1, "R4 const zero flag");
    // R10: other channels untouched by channel 2 activity
    watch(10, 2, "R10 ch1 independent");

    // R2: stop all channels, counts hold
    wr(0, 32'd0);
    watch(0, 1, "R2 run cleared");
    watch(6, 20, "R2 ch0 hold");
    extPulse(14, "R2 ch2 ext ignored when stopped");
    watch(10, 20, "R2 ch1 hold");

    summary();
  end
endmodule